// File: doc/BRIEF.md
# Fractional Accumulator Add Unit

This block is the add path of a fixed-point signal processor's data unit. It holds two 56-bit destination accumulators, A and B. Each accumulator is split into an 8-bit guard (extension) field, a 24-bit upper fraction and a 24-bit lower fraction. On each enabled clock edge it takes one source operand, aligns it to 56 bits under fractional two's-complement rules, adds it to the selected accumulator and writes the sum back into that accumulator. In the same edge it records five condition flags that describe the sum.

The source may be a 24-bit word, a 48-bit long word or a full 56-bit accumulator value. A word is a fraction, so it is placed in the upper fraction field, zero-filled below and sign-extended above. A long word is sign-extended from its bit 47. An accumulator value is used unchanged. Instruction decode, data moves and readout limiting are left to the surrounding logic.

Top module: `frac_acc_add`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators and all five flags are cleared to zero at that edge.
- R2: With `src_kind` = 0 (word), the operand is `src_bus[23:0]`. It is placed at bits 47..24, bits 23..0 are zero and bits 55..48 copy bit 23. Word 0xFFFFFF added to 0x00_000100_000000 gives 0x00_0000FF_000000.
- R3: With `src_kind` = 1 (long word), the operand is `src_bus[47:0]`, sign-extended from bit 47 to 56 bits.
- R4: With `src_kind` = 2 or 3 (accumulator), all 56 bits of `src_bus` are added without alignment.
- R5: `dst_sel` = 0 writes the sum to A and `dst_sel` = 1 writes it to B. The accumulator not selected keeps its value.
- R6: On an edge where `en` is low and `rst` is low, both accumulators and all flags keep their values.
- R7: `flag_c` is the carry out of bit 55 of the unsigned 56-bit addition of the aligned source and the old destination.
- R8: `flag_v` is set when the aligned source and the old destination agree in bit 55 and the sum differs from them in bit 55.
- R9: `flag_z` is set when all 56 bits of the sum are zero. `flag_n` equals bit 55 of the sum.
- R10: `flag_e` is set when bits 55..47 of the sum are not all equal.
- R11: The accumulators and flags change only at a clock edge, with the enable sampled at that edge. Results appear on the outputs one cycle after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Perform the add at this edge |
| src_kind | input | 2 | Source type: 0 word, 1 long word, 2 or 3 accumulator |
| src_bus | input | 56 | Source operand; low bits are used for the narrower types |
| dst_sel | input | 1 | Destination: 0 = A, 1 = B |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flag_c | output | 1 | Carry out of the 56-bit add |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Sum is zero |
| flag_n | output | 1 | Sum is negative |
| flag_e | output | 1 | Guard field in use |

## Verification
Every result of this block appears one clock after the edge that samples `en`, `src_kind`, `src_bus` and `dst_sel`. That covers both accumulators and all five flags. The bench drives its inputs at falling edges. Its reference model updates at each rising edge from the same inputs, and it compares every output against the model at the next falling edge, so each comparison falls in the cycle where the registered result is already stable. The directed checks wait one full cycle after each operation before they sample. This lets them confirm the worked example, the carry, the overflow, the zero result and the idle cycles.

// File: rtl/frac_acc_pkg.sv
package frac_acc_pkg;

    typedef enum logic [1:0] {
        SRC_WORD    = 2'd0,
        SRC_LONG    = 2'd1,
        SRC_ACC     = 2'd2,
        SRC_ACC_ALT = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic e;
    } flags_t;

endpackage

// File: rtl/frac_align.sv
module frac_align
    import frac_acc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int EXT_W  = 8
) (
    input  logic [1:0]                    kind,
    input  logic [EXT_W+2*WORD_W-1:0]     src,
    output logic [EXT_W+2*WORD_W-1:0]     aligned
);
    localparam int LONG_W = 2 * WORD_W;
    localparam int ACC_W  = EXT_W + LONG_W;

    logic [WORD_W-1:0] word_part;
    logic [LONG_W-1:0] long_part;

    assign word_part = src[WORD_W-1:0];
    assign long_part = src[LONG_W-1:0];

    always_comb begin
        case (src_kind_e'(kind))
            SRC_WORD: aligned = {{EXT_W{word_part[WORD_W-1]}}, word_part, {WORD_W{1'b0}}};
            SRC_LONG: aligned = {{EXT_W{long_part[LONG_W-1]}}, long_part};
            default:  aligned = src[ACC_W-1:0];
        endcase
    end

    // R2: a word source never carries low-fraction bits
    always_comb begin
        if (kind == 2'd0) begin
            AST_WORD_LOW_ZERO: assert (aligned[WORD_W-1:0] == '0); // R2
        end
    end
endmodule

// File: rtl/frac_sum_flags.sv
module frac_sum_flags
    import frac_acc_pkg::*;
#(
    parameter int ACC_W = 56,
    parameter int EXT_W = 8
) (
    input  logic [ACC_W-1:0] dst,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] sum,
    output flags_t           flags
);
    localparam int GUARD_W = EXT_W + 1;

    logic [ACC_W:0]       wide;
    logic [GUARD_W-1:0]   guard;

    always_comb begin
        wide  = {1'b0, dst} + {1'b0, addend};
        sum   = wide[ACC_W-1:0];
        guard = sum[ACC_W-1 -: GUARD_W];
        flags.c = wide[ACC_W];
        flags.v = (dst[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != dst[ACC_W-1]);
        flags.z = (sum == '0);
        flags.n = sum[ACC_W-1];
        flags.e = !((&guard) || (~|guard));
    end
endmodule

// File: rtl/frac_acc_add.sv
module frac_acc_add
    import frac_acc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int EXT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [1:0]                     src_kind,
    input  logic [EXT_W+2*WORD_W-1:0]      src_bus,
    input  logic                           dst_sel,
    output logic [EXT_W+2*WORD_W-1:0]      acc_a,
    output logic [EXT_W+2*WORD_W-1:0]      acc_b,
    output logic                           flag_c,
    output logic                           flag_v,
    output logic                           flag_z,
    output logic                           flag_n,
    output logic                           flag_e
);
    localparam int LONG_W = 2 * WORD_W;
    localparam int ACC_W  = EXT_W + LONG_W;

    typedef struct packed {
        logic [ACC_W-1:0] a;
        logic [ACC_W-1:0] b;
        flags_t           f;
    } state_t;

    state_t           st_d, st_q;
    logic [ACC_W-1:0] aligned;
    logic [ACC_W-1:0] dst_cur;
    logic [ACC_W-1:0] sum;
    flags_t           sum_flags;

    frac_align #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_align (
        .kind    (src_kind),
        .src     (src_bus),
        .aligned (aligned)
    );

    assign dst_cur = dst_sel ? st_q.b : st_q.a;

    frac_sum_flags #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_sum (
        .dst    (dst_cur),
        .addend (aligned),
        .sum    (sum),
        .flags  (sum_flags)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (dst_sel) st_d.b = sum;
            else         st_d.a = sum;
            st_d.f = sum_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_a  = st_q.a;
    assign acc_b  = st_q.b;
    assign flag_c = st_q.f.c;
    assign flag_v = st_q.f.v;
    assign flag_z = st_q.f.z;
    assign flag_n = st_q.f.n;
    assign flag_e = st_q.f.e;

    logic warm_q;
    always_ff @(posedge clk) begin
        if (rst) warm_q <= 1'b0;
        else     warm_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_a == '0 && acc_b == '0 && st_q.f == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !warm_q)
        !$past(en) |-> ($stable(acc_a) && $stable(acc_b) && $stable(st_q.f))); // R6

    AST_B_KEPT: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && !$past(dst_sel)) |-> $stable(acc_b)); // R5

    AST_A_KEPT: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && $past(dst_sel)) |-> $stable(acc_a)); // R5

    AST_ZERO_NEG_A: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && !$past(dst_sel)) |-> (flag_z == (acc_a == '0) && flag_n == acc_a[ACC_W-1])); // R9

    AST_EXT_FLAG_B: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && $past(dst_sel)) |->
        (flag_e == !((&acc_b[ACC_W-1 -: EXT_W+1]) || (~|acc_b[ACC_W-1 -: EXT_W+1])))); // R10

    AST_OVERFLOW_A: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && !$past(dst_sel)) |->
        (flag_v == (($past(aligned[ACC_W-1]) == $past(acc_a[ACC_W-1])) &&
                    (acc_a[ACC_W-1] != $past(acc_a[ACC_W-1]))))); // R8

    AST_CARRY_A: assert property (@(posedge clk) disable iff (rst || !warm_q)
        ($past(en) && !$past(dst_sel)) |->
        (flag_c == (acc_a < $past(acc_a)))); // R7
endmodule

// File: tb/frac_acc_add_tb.sv
module frac_acc_add_tb;
    localparam longint MASK56 = 64'h00FF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  src_kind = 2'd0;
    logic [55:0] src_bus = '0;
    logic        dst_sel = 1'b0;
    logic [55:0] acc_a, acc_b;
    logic        flag_c, flag_v, flag_z, flag_n, flag_e;

    always #2 clk = ~clk;

    frac_acc_add u_dut (
        .clk(clk), .rst(rst), .en(en), .src_kind(src_kind), .src_bus(src_bus),
        .dst_sel(dst_sel), .acc_a(acc_a), .acc_b(acc_b), .flag_c(flag_c),
        .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n), .flag_e(flag_e)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    longint m_a = 0, m_b = 0;
    bit mc, mv, mz, mn, me;
    string tag_dst = "R1";
    string tag_oth = "R1";

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_a = 0; m_b = 0; {mc, mv, mz, mn, me} = '0;
            tag_dst = "R1"; tag_oth = "R1";
        end else if (en) begin
            longint al, d, s, sd, sa, ss, top;
            case (src_kind)
                2'd0: begin al = (longint'($signed(src_bus[23:0])) * 64'sd16777216) & MASK56; tag_dst = "R2"; end
                2'd1: begin al = longint'($signed(src_bus[47:0])) & MASK56; tag_dst = "R3"; end
                default: begin al = longint'(src_bus) & MASK56; tag_dst = "R4"; end
            endcase
            tag_oth = "R5";
            d = dst_sel ? m_b : m_a;
            s = d + al;
            mc = s[56];
            s = s & MASK56;
            sd = longint'($signed(d[55:0]));
            sa = longint'($signed(al[55:0]));
            ss = sd + sa;
            mv = (ss > 64'sh007F_FFFF_FFFF_FFFF) || (ss < -64'sh0080_0000_0000_0000);
            mz = (s == 0);
            mn = s[55];
            top = s >> 47;
            me = (top != 0) && (top != 64'h1FF);
            if (dst_sel) m_b = s; else m_a = s;
        end else begin
            tag_dst = "R6"; tag_oth = "R6";
        end
    end

    // per-cycle comparison, away from the active edge (R11)
    always @(negedge clk) begin
        if (started && !done) begin
            if (dst_sel_last) begin
                chk(tag_dst, longint'(acc_b), m_b); chk(tag_oth, longint'(acc_a), m_a);
            end else begin
                chk(tag_dst, longint'(acc_a), m_a); chk(tag_oth, longint'(acc_b), m_b);
            end
            chk("R7", longint'(flag_c), longint'(mc));
            chk("R8", longint'(flag_v), longint'(mv));
            chk("R9", longint'({flag_z, flag_n}), longint'({mz, mn}));
            chk("R10", longint'(flag_e), longint'(me));
        end
    end

    bit dst_sel_last = 0;
    always @(posedge clk) if (en) dst_sel_last <= dst_sel;

    task automatic op(input logic [1:0] k, input logic [55:0] v, input logic d);
        src_kind = k; src_bus = v; dst_sel = d; en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", longint'(acc_a), 0);
        chk("R1", longint'(acc_b), 0);
        chk("R1", longint'({flag_c, flag_v, flag_z, flag_n, flag_e}), 0);

        op(2'd2, 56'h00_000100_000000, 1'b0);
        chk("R11", longint'(acc_a), 64'h0000_0001_0000_0000);
        op(2'd0, 56'h00_000000_FFFFFF, 1'b0);
        chk("R2", longint'(acc_a), 64'h0000_0000_FF00_0000);
        chk("R7", longint'(flag_c), 1);

        op(2'd1, 56'h00_800000_000000, 1'b1);
        chk("R3", longint'(acc_b), 64'h00FF_8000_0000_0000);
        chk("R5", longint'(acc_a), 64'h0000_0000_FF00_0000);
        chk("R9", longint'(flag_n), 1);

        op(2'd2, 56'h7F_FFFFFF_FFFFFF, 1'b0);
        chk("R8", longint'(flag_v), 1);
        chk("R10", longint'(flag_e), 1);

        op(2'd3, 56'h00_800000_000000, 1'b1);
        chk("R4", longint'(acc_b), 0);
        chk("R9", longint'(flag_z), 1);

        src_kind = 2'd2; src_bus = 56'h12_345678_9ABCDE; dst_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", longint'(acc_a), 64'h0080_0000_FEFF_FFFF);
        chk("R6", longint'(flag_z), 1);

        for (int i = 0; i < 600; i++) begin
            en = ($urandom_range(0, 3) != 0);
            src_kind = 2'($urandom_range(0, 3));
            src_bus = {$urandom(), $urandom()};
            dst_sel = 1'($urandom_range(0, 1));
            if (i == 300) rst = 1'b1;
            if (i == 302) rst = 1'b0;
            @(negedge clk);
        end
        en = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule